// File: doc/BRIEF.md
# Sensor Measurement Sequencer

This block drives one complete measurement of an attached sensor each time it receives a command. While idle it sits in a low-power sleep state with every front-end block and the sensor supply switched off. A start pulse captures the sensor-type code, the warm-up code and a supply option. The block then walks a fixed seven-step sequence: read the type, strobe a configuration load, power the front end, hold for the warm-up time, request a conversion and wait for it to complete, power the front end down, and return to sleep.

The analog and digital enable masks depend on the sensor type. Eight types exist. Types 1 to 5 are analog front ends: a buffered voltage input, a bridge, a current loop, a resistor and a capacitor. Types 6 to 8 are serial-digital. The warm-up time is `(code + 1)` ticks of a prescaled time base, where one tick is 100 ms at the default divider. This gives a range of 100 ms to 25.6 s. A power-state code tells the rest of the unit whether it is asleep, processing, or measuring. The conversion itself is performed elsewhere and only handshaked here.

Top module: `sensor_seq_top`

## Requirements
- R1: During and after reset the block is in sleep. `pwr_state_o` is 2'b00 and every other output is 0.
- R2: After a start with a valid type, the sequence runs in this order:
  - one cycle later `pwr_state_o` becomes 2'b01 (processing, type read);
  - the next cycle `load_cfg_o` is high for exactly one cycle, still in processing;
  - then the front end switches on and `pwr_state_o` becomes 2'b10 (measuring).
- R3: Count the clock cycles from the first cycle the enables are on to the first cycle `acq_req_o` is high. This count is `1 + (code + 1) * TICK_DIV`, where code is the 8-bit warm-up value captured at start. Codes 0 and 255 are the shortest and longest settings.
- R4: While measuring, the masks follow the type as `ana_en_o`/`dig_en_o`:
  - type 1: 6'b100001/4'b0000
  - type 2: 6'b100111/4'b0000
  - type 3: 6'b100001/4'b0000
  - type 4: 6'b101011/4'b0000
  - type 5: 6'b010001/4'b1000
  - type 6: 6'b000000/4'b0001
  - type 7: 6'b000000/4'b0010
  - type 8: 6'b000000/4'b0100
- R5: For types 6 to 8 the analog mask is zero and `sup_en_o` equals the `dig_sup_i` value captured at start. For types 1 to 5 `sup_en_o` is 1 while measuring, whatever `dig_sup_i` was.
- R6: `pwr_state_o` takes one of three codes: 2'b00 (sleep), 2'b01 (processing) or 2'b10 (measuring). It never takes 2'b11.
- R7: Whenever `pwr_state_o` is not 2'b10, `ana_en_o`, `dig_en_o` and `sup_en_o` are all 0.
- R8: `acq_req_o` stays high until `acq_done_i` is sampled high. On the next cycle all enables and `acq_req_o` are 0 and the state is processing (power-down). One cycle after that the block is back in sleep.
- R9: A type code of 0 or above 8 makes the block skip the power-up:
  - no `load_cfg_o` pulse and no enables;
  - two cycles after the start, `err_o` is 1, `done_o` pulses and the state is sleep.
- R10: A start pulse while a sequence is running is ignored. The warm-up length and the masks of the running sequence are unchanged.
- R11: `done_o` is high for exactly one cycle, on the first sleep cycle after a sequence. `err_o` is cleared by the next accepted start.
- R12: The type, warm-up code and supply option are captured only when a start is accepted. Changing those inputs later in the sequence has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start one measurement sequence (accepted only in sleep) |
| cfg_type_i | input | TYPE_W | Sensor type code, 1 to 8 valid |
| warm_code_i | input | CODE_W | Warm-up code, delay = (code+1) ticks |
| dig_sup_i | input | 1 | Supply option for serial-digital types |
| acq_done_i | input | 1 | Conversion finished |
| load_cfg_o | output | 1 | One-cycle configuration load strobe |
| ana_en_o | output | 6 | Analog block enables: buffer, instrumentation amp, offset DAC, current DAC, oscillator comparator, ADC (bit 0 to 5) |
| dig_en_o | output | 4 | Digital block enables: UART, SPI, I2C, pulse counter (bit 0 to 3) |
| sup_en_o | output | 1 | Sensor supply enable |
| acq_req_o | output | 1 | Conversion request, held until done |
| pwr_state_o | output | 2 | 00 sleep, 01 processing, 10 measuring |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last sequence aborted on an invalid type |

## Verification
A corrupted state register shows at the ports in the same cycle. The state code is registered from the same next-state value that drives the masks, so a bad step gives either an illegal power code or enables outside the measuring state. A miscounting prescaler or tick counter shows only at the rising edge of the conversion request. That is up to 25.6 s late at the real divider, so the warm-up cycle count is measured exactly with a small divider and with the extreme codes. A wrong type capture shows as a wrong mask in the first measuring cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP, ST_READ, ST_LOAD, ST_FEON, ST_WARM, ST_ACQ, ST_FEOFF
  } seq_st_e;

  localparam int ANA_W = 6;
  localparam int DIG_W = 4;

  localparam logic [1:0] PWR_SLEEP = 2'b00;
  localparam logic [1:0] PWR_PROC  = 2'b01;
  localparam logic [1:0] PWR_MEAS  = 2'b10;

  // analog enable bit positions
  localparam int A_BUF  = 0;
  localparam int A_INA  = 1;
  localparam int A_OFS  = 2;
  localparam int A_IDAC = 3;
  localparam int A_CMP  = 4;
  localparam int A_ADC  = 5;
  // digital enable bit positions
  localparam int D_UART = 0;
  localparam int D_SPI  = 1;
  localparam int D_I2C  = 2;
  localparam int D_CNT  = 3;

  localparam int TYPE_FIRST   = 1;
  localparam int TYPE_LAST    = 8;
  localparam int TYPE_DIG_MIN = 6;
endpackage

// File: rtl/seq_warm_timer.sv
module seq_warm_timer #(
  parameter int TICK_DIV = 5_000_000,
  parameter int CODE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] limit,
  output logic              expire
);
  logic              tick;
  logic [CODE_W-1:0] n_q;

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] PMAX = PW'(TICK_DIV - 1);
      logic [PW-1:0] p_q;
      always_ff @(posedge clk) begin
        if (rst || !run)    p_q <= '0;
        else if (p_q == PMAX) p_q <= '0;
        else                p_q <= p_q + 1'b1;
      end
      assign tick = run && (p_q == PMAX);
    end else begin : g_nopre
      assign tick = run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run) n_q <= '0;
    else if (tick)   n_q <= n_q + 1'b1;
  end

  assign expire = tick && (n_q == limit);
endmodule

// File: rtl/seq_mask_lut.sv
module seq_mask_lut
  import seq_pkg::*;
#(
  parameter int TYPE_W = 4
) (
  input  logic [TYPE_W-1:0] sel_type,
  input  logic              dig_sup,
  output logic              valid,
  output logic [ANA_W-1:0]  ana,
  output logic [DIG_W-1:0]  dig,
  output logic              sup
);
  always_comb begin
    ana = '0;
    dig = '0;
    case (int'(sel_type))
      1: begin ana[A_BUF] = 1'b1; ana[A_ADC] = 1'b1; end
      2: begin ana[A_BUF] = 1'b1; ana[A_INA] = 1'b1;
               ana[A_OFS] = 1'b1; ana[A_ADC] = 1'b1; end
      3: begin ana[A_BUF] = 1'b1; ana[A_ADC] = 1'b1; end
      4: begin ana[A_BUF] = 1'b1; ana[A_INA] = 1'b1;
               ana[A_IDAC] = 1'b1; ana[A_ADC] = 1'b1; end
      5: begin ana[A_BUF] = 1'b1; ana[A_CMP] = 1'b1; dig[D_CNT] = 1'b1; end
      6: dig[D_UART] = 1'b1;
      7: dig[D_SPI]  = 1'b1;
      8: dig[D_I2C]  = 1'b1;
      default: ;
    endcase
  end

  assign valid = (int'(sel_type) >= TYPE_FIRST) && (int'(sel_type) <= TYPE_LAST);
  assign sup   = (int'(sel_type) >= TYPE_DIG_MIN) ? dig_sup : valid;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TYPE_W-1:0] cfg_type,
  input  logic [CODE_W-1:0] warm_code,
  input  logic              dig_sup,
  input  logic              acq_done,
  input  logic              t_expire,
  input  logic              lut_valid,
  input  logic [ANA_W-1:0]  lut_ana,
  input  logic [DIG_W-1:0]  lut_dig,
  input  logic              lut_sup,
  output logic              t_run,
  output logic [CODE_W-1:0] code_q,
  output logic [TYPE_W-1:0] type_q,
  output logic              dsup_q,
  output logic              load_o,
  output logic [ANA_W-1:0]  ana_o,
  output logic [DIG_W-1:0]  dig_o,
  output logic              sup_o,
  output logic              acq_o,
  output logic [1:0]        pwr_o,
  output logic              done_o,
  output logic              err_o
);
  seq_st_e st_q, st_d;
  logic    meas_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_SLEEP: if (start) st_d = ST_READ;
      ST_READ:  st_d = lut_valid ? ST_LOAD : ST_SLEEP;
      ST_LOAD:  st_d = ST_FEON;
      ST_FEON:  st_d = ST_WARM;
      ST_WARM:  if (t_expire) st_d = ST_ACQ;
      ST_ACQ:   if (acq_done) st_d = ST_FEOFF;
      ST_FEOFF: st_d = ST_SLEEP;
      default:  st_d = ST_SLEEP;
    endcase
  end

  assign meas_d = (st_d == ST_FEON) || (st_d == ST_WARM) || (st_d == ST_ACQ);
  assign t_run  = (st_q == ST_WARM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_SLEEP;
      type_q <= '0;
      code_q <= '0;
      dsup_q <= 1'b0;
      load_o <= 1'b0;
      ana_o  <= '0;
      dig_o  <= '0;
      sup_o  <= 1'b0;
      acq_o  <= 1'b0;
      pwr_o  <= PWR_SLEEP;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SLEEP && start) begin
        type_q <= cfg_type;
        code_q <= warm_code;
        dsup_q <= dig_sup;
      end
      load_o <= (st_d == ST_LOAD);
      ana_o  <= meas_d ? lut_ana : '0;
      dig_o  <= meas_d ? lut_dig : '0;
      sup_o  <= meas_d && lut_sup;
      acq_o  <= (st_d == ST_ACQ);
      pwr_o  <= meas_d ? PWR_MEAS : ((st_d == ST_SLEEP) ? PWR_SLEEP : PWR_PROC);
      done_o <= (st_d == ST_SLEEP) && (st_q != ST_SLEEP);
      if (st_q == ST_SLEEP && start)           err_o <= 1'b0;
      else if (st_q == ST_READ && !lut_valid)  err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sensor_seq_top.sv
module sensor_seq_top #(
  parameter int TICK_DIV = 5_000_000,
  parameter int TYPE_W   = 4,
  parameter int CODE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [TYPE_W-1:0] cfg_type_i,
  input  logic [CODE_W-1:0] warm_code_i,
  input  logic              dig_sup_i,
  input  logic              acq_done_i,
  output logic              load_cfg_o,
  output logic [5:0]        ana_en_o,
  output logic [3:0]        dig_en_o,
  output logic              sup_en_o,
  output logic              acq_req_o,
  output logic [1:0]        pwr_state_o,
  output logic              done_o,
  output logic              err_o
);
  import seq_pkg::*;

  logic              t_run, t_expire, lut_valid, lut_sup, dsup_q;
  logic [CODE_W-1:0] code_q;
  logic [TYPE_W-1:0] type_q;
  logic [ANA_W-1:0]  lut_ana;
  logic [DIG_W-1:0]  lut_dig;

  seq_warm_timer #(.TICK_DIV(TICK_DIV), .CODE_W(CODE_W)) u_tmr (
    .clk(clk), .rst(rst), .run(t_run), .limit(code_q), .expire(t_expire)
  );

  seq_mask_lut #(.TYPE_W(TYPE_W)) u_lut (
    .sel_type(type_q), .dig_sup(dsup_q), .valid(lut_valid),
    .ana(lut_ana), .dig(lut_dig), .sup(lut_sup)
  );

  seq_ctrl #(.TYPE_W(TYPE_W), .CODE_W(CODE_W)) u_ctl (
    .clk(clk), .rst(rst), .start(start_i), .cfg_type(cfg_type_i),
    .warm_code(warm_code_i), .dig_sup(dig_sup_i), .acq_done(acq_done_i),
    .t_expire(t_expire), .lut_valid(lut_valid), .lut_ana(lut_ana),
    .lut_dig(lut_dig), .lut_sup(lut_sup), .t_run(t_run), .code_q(code_q),
    .type_q(type_q), .dsup_q(dsup_q), .load_o(load_cfg_o), .ana_o(ana_en_o),
    .dig_o(dig_en_o), .sup_o(sup_en_o), .acq_o(acq_req_o),
    .pwr_o(pwr_state_o), .done_o(done_o), .err_o(err_o)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       acq_done_i,
  input logic       load_cfg_o,
  input logic [5:0] ana_en_o,
  input logic [3:0] dig_en_o,
  input logic       sup_en_o,
  input logic       acq_req_o,
  input logic [1:0] pwr_state_o,
  input logic       done_o,
  input logic       err_o
);
  // R6
  pwr_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_state_o != 2'b11);

  // R7
  off_outside_meas_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state_o != 2'b10) |-> (ana_en_o == '0 && dig_en_o == '0 && !sup_en_o));

  // R8
  acq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acq_req_o && !acq_done_i) |=> acq_req_o);

  // R8
  acq_release_chk: assert property (@(posedge clk) disable iff (rst)
    (acq_req_o && acq_done_i) |=> (!acq_req_o && pwr_state_o == 2'b01));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11
  done_in_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> pwr_state_o == 2'b00);

  // R2
  load_in_proc_chk: assert property (@(posedge clk) disable iff (rst)
    load_cfg_o |-> (pwr_state_o == 2'b01));

  // R2
  load_then_meas_chk: assert property (@(posedge clk) disable iff (rst)
    load_cfg_o |=> (pwr_state_o == 2'b10 && !load_cfg_o));

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o);
endmodule

bind sensor_seq_top seq_chk u_chk (
  .clk(clk), .rst(rst), .acq_done_i(acq_done_i), .load_cfg_o(load_cfg_o),
  .ana_en_o(ana_en_o), .dig_en_o(dig_en_o), .sup_en_o(sup_en_o),
  .acq_req_o(acq_req_o), .pwr_state_o(pwr_state_o), .done_o(done_o),
  .err_o(err_o)
);

// File: tb/sim_sensor_seq_top.sv
module sim_sensor_seq_top;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [3:0] cfg_type_i = '0;
  logic [7:0] warm_code_i = '0;
  logic       dig_sup_i = 1'b0;
  logic       acq_done_i = 1'b0;
  logic       load_cfg_o, sup_en_o, acq_req_o, done_o, err_o;
  logic [5:0] ana_en_o;
  logic [3:0] dig_en_o;
  logic [1:0] pwr_state_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sensor_seq_top #(.TICK_DIV(DIV), .TYPE_W(4), .CODE_W(8)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_type_i(cfg_type_i),
    .warm_code_i(warm_code_i), .dig_sup_i(dig_sup_i), .acq_done_i(acq_done_i),
    .load_cfg_o(load_cfg_o), .ana_en_o(ana_en_o), .dig_en_o(dig_en_o),
    .sup_en_o(sup_en_o), .acq_req_o(acq_req_o), .pwr_state_o(pwr_state_o),
    .done_o(done_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [3:0] t;
    logic [7:0] c;
    logic       ds;
    logic [5:0] a;
    logic [3:0] d;
    logic       s;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{4'd1, 8'd0, 1'b0, 6'b100001, 4'b0000, 1'b1},
    '{4'd2, 8'd1, 1'b0, 6'b100111, 4'b0000, 1'b1},
    '{4'd3, 8'd2, 1'b0, 6'b100001, 4'b0000, 1'b1},
    '{4'd4, 8'd3, 1'b0, 6'b101011, 4'b0000, 1'b1},
    '{4'd5, 8'd0, 1'b0, 6'b010001, 4'b1000, 1'b1},
    '{4'd6, 8'd1, 1'b0, 6'b000000, 4'b0001, 1'b0},
    '{4'd6, 8'd0, 1'b1, 6'b000000, 4'b0001, 1'b1},
    '{4'd7, 8'd2, 1'b1, 6'b000000, 4'b0010, 1'b1},
    '{4'd8, 8'd0, 1'b0, 6'b000000, 4'b0100, 1'b0},
    '{4'd1, 8'd5, 1'b1, 6'b100001, 4'b0000, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      summary();
    end
  end

  // poke: pulse a start with another type during warm-up (R10, R12)
  task automatic run_seq(input vec_t v, input bit poke);
    int cnt;
    int expw;
    @(negedge clk);
    start_i = 1'b1; cfg_type_i = v.t; warm_code_i = v.c; dig_sup_i = v.ds;
    @(negedge clk);
    start_i = 1'b0;
    chk(pwr_state_o == 2'b01 && !load_cfg_o, "R2 read step", pwr_state_o, 1);
    chk(err_o == 1'b0, "R11 err cleared on start", err_o, 0);
    @(negedge clk);
    chk(load_cfg_o && pwr_state_o == 2'b01 && ana_en_o == 0 && !sup_en_o,
        "R2 load strobe", {load_cfg_o, pwr_state_o}, 3'b101);
    @(negedge clk);
    chk(pwr_state_o == 2'b10 && !load_cfg_o, "R2 front end on", pwr_state_o, 2);
    chk(ana_en_o == v.a, "R4 analog mask", ana_en_o, v.a);
    chk(dig_en_o == v.d, "R4 digital mask", dig_en_o, v.d);
    chk(sup_en_o == v.s, "R5 supply", sup_en_o, v.s);
    cnt = 0;
    while (!acq_req_o && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 1) begin
        start_i = 1'b1; cfg_type_i = 4'd7; warm_code_i = 8'd200; dig_sup_i = ~v.ds;
      end else if (poke && cnt == 2) begin
        start_i = 1'b0;
      end
    end
    expw = 1 + (int'(v.c) + 1) * DIV;
    chk(cnt == expw, poke ? "R10 warm-up with busy start" : "R3 warm-up length", cnt, expw);
    chk(ana_en_o == v.a && dig_en_o == v.d && sup_en_o == v.s,
        poke ? "R12 masks after input change" : "R4 masks at acquire", ana_en_o, v.a);
    repeat (3) @(negedge clk);
    chk(acq_req_o && pwr_state_o == 2'b10, "R8 acquire held", acq_req_o, 1);
    acq_done_i = 1'b1;
    @(negedge clk);
    acq_done_i = 1'b0;
    chk(!acq_req_o && ana_en_o == 0 && dig_en_o == 0 && !sup_en_o && pwr_state_o == 2'b01,
        "R8 power down", {acq_req_o, sup_en_o, pwr_state_o}, 1);
    @(negedge clk);
    chk(done_o && pwr_state_o == 2'b00 && !err_o, "R11 done pulse", {done_o, pwr_state_o}, 4);
    @(negedge clk);
    chk(!done_o, "R11 done one cycle", done_o, 0);
  endtask

  task automatic run_bad(input logic [3:0] t);
    @(negedge clk);
    start_i = 1'b1; cfg_type_i = t; warm_code_i = 8'd3;
    @(negedge clk);
    start_i = 1'b0;
    chk(pwr_state_o == 2'b01 && !load_cfg_o, "R9 read step", pwr_state_o, 1);
    @(negedge clk);
    chk(err_o && done_o && pwr_state_o == 2'b00, "R9 abort", {err_o, done_o, pwr_state_o}, 12);
    chk(!load_cfg_o && ana_en_o == 0 && dig_en_o == 0 && !sup_en_o, "R9 no power-up",
        {load_cfg_o, sup_en_o}, 0);
    @(negedge clk);
    chk(!done_o && err_o && pwr_state_o == 2'b00, "R11 err held in sleep", err_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(pwr_state_o == 2'b00 && !load_cfg_o && ana_en_o == 0 && dig_en_o == 0 &&
        !sup_en_o && !acq_req_o && !done_o && !err_o, "R1 reset state", pwr_state_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(pwr_state_o == 2'b00 && !done_o && !err_o, "R1 idle after reset", pwr_state_o, 0);

    for (int i = 0; i < 10; i++) run_seq(VEC[i], 1'b0);

    // directed: invalid codes, then recovery
    run_bad(4'd0);
    run_bad(4'd9);
    run_bad(4'd15);
    run_seq(VEC[1], 1'b0);

    // directed: busy start ignored and inputs changed mid-sequence
    run_seq(VEC[3], 1'b1);

    // directed: longest warm-up code
    run_seq('{4'd2, 8'd255, 1'b0, 6'b100111, 4'b0000, 1'b1}, 1'b0);

    // directed: reset in mid-sequence returns to sleep
    @(negedge clk);
    start_i = 1'b1; cfg_type_i = 4'd4; warm_code_i = 8'd10;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(pwr_state_o == 2'b00 && ana_en_o == 0 && !sup_en_o && !acq_req_o,
        "R1 reset mid-sequence", pwr_state_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule